// File: doc/BRIEF.md
# Power-Down and Wake Reset Sequencer

This block moves a compute core into a low-power reset state and brings it back out without software stepping through each register access. It accepts one of three commands (enter, quit, full reset cycle) and turns it into an ordered series of accesses on a simple memory-mapped master port. Some accesses change one field of a control register through read-modify-write. Others poll a status bit until it reaches the wanted value. Each poll has a fixed limit on its number of reads and a programmable gap between reads.

When the sequence finishes, the block pulses `done` for one cycle and presents a 3-bit result code at the same time. A code of zero means success. A non-zero code names the poll that ran out of retries, and the sequence stops at that point with no further bus writes. A bypass input makes every command finish at once with success and no bus traffic. The register file on the far side of the port is a separate slave. It acknowledges each access with a one-cycle `bus_ack`.

Register map (word addresses): 0 idle control (idle-force at bit 0); 1 DMA pause request (whole word written); 2 DMA status (paused at bit 0); 3 core control (reset override at [1:0], clock-gate override at [9:8]); 4 memory control (RAM shutdown force at [1:0], power-state override at [5:4]); 5 status (RAM down at bit 0, core in reset at bit 1).

Top module: `lpr_sequencer`

## Requirements
- R1: Command code 01 (enter) writes, in this order: idle-force bit set to 1, the value 1 to the DMA pause register, reset override 01, clock-gate override 01, RAM shutdown force 11. It polls DMA-paused for 1 after the DMA pause write, and it polls RAM-down for 1 after the last write.
- R2: Command code 10 (quit) writes RAM force 00, then clock-gate override 00, then reset override 10. It then polls RAM-down for 0 and then in-reset for 0. Last, it writes the power-state override: 10 when `hw_gate_ok` is 1 and 11 when it is 0.
- R3: Command code 11 (reset) first reads the status register. It runs the enter sequence only when in-reset reads 0, and it then always runs the quit sequence.
- R4: Each poll makes at most RETRY_MAX reads, with at least GAP_CYCLES idle cycles between a failed read and the next read. When the limit is reached, the command ends and makes no further bus write.
- R5: The result code is 1 for a DMA-pause timeout, 2 for a RAM-down timeout, 3 for a RAM-up timeout, 4 for a reset-release timeout and 0 for success.
- R6: Every field write is a read-modify-write that leaves all bits outside the target field unchanged.
- R7: With `bypass` high, an accepted command raises `done` in the next cycle with code 0, leaves `busy` low and makes no bus access.
- R8: A command that arrives while `busy` is high is ignored. It produces no `done` and no bus access.
- R9: `done` is high for exactly one cycle per accepted command. `busy` is high from acceptance until `done`.
- R10: `bus_req` stays high with address, direction and write data stable until the cycle in which `bus_ack` is high.
- R11: After reset, `busy`, `done`, `bus_req` and the result code are all 0, and no bus request is made while the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 enter, 10 quit, 11 reset cycle, 00 none |
| bypass | input | 1 | Complete commands at once without bus traffic |
| hw_gate_ok | input | 1 | Hardware clock gating allowed; selects final power-state value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code, valid with done |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 4 | Word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle access acknowledge |

## Verification
The assertions rely on the slave answering each request with a single-cycle `bus_ack` and returning read data in that same cycle. They also rely on `bus_ack` never rising while `bus_req` is low, and on GAP_CYCLES being at least 1. The bench register model acknowledges one cycle after it sees a request and then drops the acknowledge, so it never acknowledges twice. It changes status bits only between commands or while a poll is in progress, and it holds `cmd_valid` for a single cycle on a falling-edge boundary.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int LSB_W  = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // register word addresses
    localparam addr_t RA_IDLE     = 4'd0;
    localparam addr_t RA_DMA_REQ  = 4'd1;
    localparam addr_t RA_DMA_STAT = 4'd2;
    localparam addr_t RA_CORE     = 4'd3;
    localparam addr_t RA_MEM      = 4'd4;
    localparam addr_t RA_STAT     = 4'd5;

    // field and status bit positions
    localparam logic [LSB_W-1:0] FL_IDLE   = 5'd0;
    localparam logic [LSB_W-1:0] FL_RST    = 5'd0;
    localparam logic [LSB_W-1:0] FL_GATE   = 5'd8;
    localparam logic [LSB_W-1:0] FL_RAM    = 5'd0;
    localparam logic [LSB_W-1:0] FL_PWR    = 5'd4;
    localparam logic [LSB_W-1:0] SB_PAUSED = 5'd0;
    localparam logic [LSB_W-1:0] SB_RAMDN  = 5'd0;
    localparam logic [LSB_W-1:0] SB_INRST  = 5'd1;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_ENTER = 2'b01,
        CMD_QUIT  = 2'b10,
        CMD_CYCLE = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_RMW} acc_e;

    // order matters: steps inside one sequence advance by +1
    typedef enum logic [3:0] {
        ST_IDLEF, ST_DMAP, ST_DMAW, ST_RSTON, ST_GATEON, ST_RAMOFF, ST_RAMDNW,
        ST_RAMON, ST_GATEOFF, ST_RSTOFF, ST_RAMUPW, ST_RSTW, ST_PWROVR,
        ST_CHECK
    } step_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_DMA     = 3'd1,
        ERR_RAM_DN  = 3'd2,
        ERR_RAM_UP  = 3'd3,
        ERR_RST_REL = 3'd4
    } err_e;

    typedef struct packed {
        acc_e              kind;
        logic              poll;
        addr_t             addr;
        logic [LSB_W-1:0]  lsb;
        logic              wide;
        logic [1:0]        val;
        logic [LSB_W-1:0]  pbit;
        logic              want;
        err_e              err;
    } step_t;

    function automatic word_t field_mask(logic [LSB_W-1:0] lsb, logic wide);
        word_t m;
        m = wide ? word_t'(2'b11) : word_t'(1'b1);
        return m << lsb;
    endfunction

    function automatic step_t step_desc(step_e s, logic hw_gate_ok);
        step_t d;
        d = '0;
        d.kind = ACC_RMW;
        d.wide = 1'b1;
        case (s)
            ST_IDLEF:   begin d.addr = RA_IDLE; d.lsb = FL_IDLE; d.wide = 1'b0; d.val = 2'b01; end
            ST_DMAP:    begin d.kind = ACC_WRITE; d.addr = RA_DMA_REQ; d.val = 2'b01; end
            ST_DMAW:    begin d.kind = ACC_READ; d.poll = 1'b1; d.addr = RA_DMA_STAT;
                              d.pbit = SB_PAUSED; d.want = 1'b1; d.err = ERR_DMA; end
            ST_RSTON:   begin d.addr = RA_CORE; d.lsb = FL_RST;  d.val = 2'b01; end
            ST_GATEON:  begin d.addr = RA_CORE; d.lsb = FL_GATE; d.val = 2'b01; end
            ST_RAMOFF:  begin d.addr = RA_MEM;  d.lsb = FL_RAM;  d.val = 2'b11; end
            ST_RAMDNW:  begin d.kind = ACC_READ; d.poll = 1'b1; d.addr = RA_STAT;
                              d.pbit = SB_RAMDN; d.want = 1'b1; d.err = ERR_RAM_DN; end
            ST_RAMON:   begin d.addr = RA_MEM;  d.lsb = FL_RAM;  d.val = 2'b00; end
            ST_GATEOFF: begin d.addr = RA_CORE; d.lsb = FL_GATE; d.val = 2'b00; end
            ST_RSTOFF:  begin d.addr = RA_CORE; d.lsb = FL_RST;  d.val = 2'b10; end
            ST_RAMUPW:  begin d.kind = ACC_READ; d.poll = 1'b1; d.addr = RA_STAT;
                              d.pbit = SB_RAMDN; d.want = 1'b0; d.err = ERR_RAM_UP; end
            ST_RSTW:    begin d.kind = ACC_READ; d.poll = 1'b1; d.addr = RA_STAT;
                              d.pbit = SB_INRST; d.want = 1'b0; d.err = ERR_RST_REL; end
            ST_PWROVR:  begin d.addr = RA_MEM; d.lsb = FL_PWR;
                              d.val = hw_gate_ok ? 2'b10 : 2'b11; end
            default:    begin d.kind = ACC_READ; d.addr = RA_STAT; d.pbit = SB_INRST; end
        endcase
        return d;
    endfunction

    function automatic step_e first_step(cmd_e c);
        case (c)
            CMD_ENTER: return ST_IDLEF;
            CMD_QUIT:  return ST_RAMON;
            default:   return ST_CHECK;
        endcase
    endfunction
endpackage

// File: rtl/lpr_bus_port.sv
module lpr_bus_port
    import lpr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  acc_e  kind,
    input  addr_t addr,
    input  word_t mask,
    input  word_t wval,
    output logic  acc_done,
    output word_t acc_rdata,
    output logic  bus_req,
    output logic  bus_we,
    output addr_t bus_addr,
    output word_t bus_wdata,
    input  word_t bus_rdata,
    input  logic  bus_ack
);
    typedef enum logic [1:0] {BP_IDLE, BP_RD, BP_WR} bp_e;

    bp_e   state_q;
    acc_e  kind_q;
    addr_t addr_q;
    word_t mask_q;
    word_t val_q;
    word_t wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= BP_IDLE;
            kind_q    <= ACC_READ;
            addr_q    <= '0;
            mask_q    <= '0;
            val_q     <= '0;
            wdata_q   <= '0;
            acc_rdata <= '0;
            acc_done  <= 1'b0;
        end else begin
            acc_done <= 1'b0;
            case (state_q)
                BP_IDLE: if (start) begin
                    kind_q  <= kind;
                    addr_q  <= addr;
                    mask_q  <= mask;
                    val_q   <= wval;
                    wdata_q <= wval;
                    state_q <= (kind == ACC_WRITE) ? BP_WR : BP_RD;
                end
                BP_RD: if (bus_ack) begin
                    acc_rdata <= bus_rdata;
                    if (kind_q == ACC_READ) begin
                        acc_done <= 1'b1;
                        state_q  <= BP_IDLE;
                    end else begin
                        wdata_q <= (bus_rdata & ~mask_q) | (val_q & mask_q);
                        state_q <= BP_WR;
                    end
                end
                BP_WR: if (bus_ack) begin
                    acc_done <= 1'b1;
                    state_q  <= BP_IDLE;
                end
                default: state_q <= BP_IDLE;
            endcase
        end
    end

    assign bus_req   = (state_q != BP_IDLE);
    assign bus_we    = (state_q == BP_WR);
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

    // R10: request and its payload hold until acknowledged
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
endmodule

// File: rtl/lpr_poll_pacer.sv
module lpr_poll_pacer #(
    parameter int RETRY_MAX  = 120,
    parameter int GAP_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic miss,
    output logic last_try,
    output logic resume
);
    localparam int TRY_W = $clog2(RETRY_MAX + 1);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    logic [TRY_W-1:0] tries_q;
    logic [GAP_W-1:0] gap_q;
    logic             waiting_q;

    always_ff @(posedge clk) begin
        if (rst || restart) tries_q <= '0;
        else if (miss)      tries_q <= tries_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting_q <= 1'b0;
            gap_q     <= '0;
        end else if (miss) begin
            waiting_q <= 1'b1;
            gap_q     <= GAP_W'(GAP_CYCLES - 1);
        end else if (waiting_q) begin
            if (gap_q == '0) waiting_q <= 1'b0;
            else             gap_q     <= gap_q - 1'b1;
        end
    end

    assign last_try = (tries_q == TRY_W'(RETRY_MAX - 1));
    assign resume   = waiting_q && (gap_q == '0);

    // R4: a retry is only scheduled while reads remain in the budget
    a_r4_try_bound: assert property (@(posedge clk) disable iff (rst)
        miss |-> tries_q < TRY_W'(RETRY_MAX - 1));
endmodule

// File: rtl/lpr_seq_ctrl.sv
module lpr_seq_ctrl
    import lpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       bypass,
    input  logic       hw_gate_ok,
    input  logic       acc_done,
    input  word_t      acc_rdata,
    input  logic       last_try,
    input  logic       resume,
    output logic       busy,
    output logic       done,
    output logic [2:0] err_code,
    output logic       acc_start,
    output acc_e       acc_kind,
    output addr_t      acc_addr,
    output word_t      acc_mask,
    output word_t      acc_wval,
    output logic       restart,
    output logic       miss
);
    typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_ACC, PH_GAP} phase_e;

    phase_e phase_q;
    step_e  step_q;
    cmd_e   mode_q;
    err_e   err_q;
    logic   done_q;

    step_t desc;
    cmd_e  cmd_in;
    logic  accept, hit, at_result, is_check, fail_now, step_ok, seq_end;

    assign desc      = step_desc(step_q, hw_gate_ok);
    assign cmd_in    = cmd_e'(cmd_op);
    assign accept    = cmd_valid && (cmd_in != CMD_NONE) && (phase_q == PH_IDLE);
    assign hit       = (acc_rdata[desc.pbit] == desc.want);
    assign at_result = (phase_q == PH_ACC) && acc_done;
    assign is_check  = (desc.kind == ACC_READ) && !desc.poll;
    assign fail_now  = at_result && desc.poll && !hit && last_try;
    assign miss      = at_result && desc.poll && !hit && !last_try;
    assign step_ok   = at_result && !is_check && !(desc.poll && !hit);
    assign seq_end   = step_ok && (((step_q == ST_RAMDNW) && (mode_q != CMD_CYCLE))
                                   || (step_q == ST_PWROVR));
    assign restart   = (accept && !bypass) || (at_result && !miss && !fail_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= ST_CHECK;
            mode_q  <= CMD_NONE;
            err_q   <= ERR_NONE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= ERR_NONE;
            case (phase_q)
                PH_IDLE: if (accept) begin
                    if (bypass) begin
                        done_q <= 1'b1;
                    end else begin
                        mode_q  <= cmd_in;
                        step_q  <= first_step(cmd_in);
                        phase_q <= PH_ISSUE;
                    end
                end
                PH_ISSUE: phase_q <= PH_ACC;
                PH_ACC: if (acc_done) begin
                    if (is_check) begin
                        step_q  <= acc_rdata[SB_INRST] ? ST_RAMON : ST_IDLEF;
                        phase_q <= PH_ISSUE;
                    end else if (fail_now) begin
                        done_q  <= 1'b1;
                        err_q   <= desc.err;
                        phase_q <= PH_IDLE;
                    end else if (miss) begin
                        phase_q <= PH_GAP;
                    end else if (seq_end) begin
                        done_q  <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else if (step_q == ST_RAMDNW) begin
                        step_q  <= ST_RAMON;
                        phase_q <= PH_ISSUE;
                    end else begin
                        step_q  <= step_e'(step_q + 4'd1);
                        phase_q <= PH_ISSUE;
                    end
                end
                PH_GAP: if (resume) phase_q <= PH_ISSUE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase_q != PH_IDLE);
    assign done      = done_q;
    assign err_code  = err_q;
    assign acc_start = (phase_q == PH_ISSUE);
    assign acc_kind  = desc.kind;
    assign acc_addr  = desc.addr;
    assign acc_mask  = field_mask(desc.lsb, desc.wide);
    assign acc_wval  = word_t'(desc.val) << desc.lsb;

    // R9: completion is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: a bypassed command completes in the next cycle with success
    a_r7_bypass_quick: assert property (@(posedge clk) disable iff (rst)
        bypass && cmd_valid && (cmd_op != 2'b00) && !busy |=> done && (err_code == 3'd0) && !busy);
    // R8: a command during a running sequence does not alter the sequence mode
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        busy && cmd_valid |=> $stable(mode_q));
endmodule

// File: rtl/lpr_sequencer.sv
module lpr_sequencer
    import lpr_pkg::*;
#(
    parameter int RETRY_MAX  = 120,
    parameter int GAP_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              bypass,
    input  logic              hw_gate_ok,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    logic  acc_start, acc_done, last_try, resume, restart, miss;
    acc_e  acc_kind;
    addr_t acc_addr;
    word_t acc_mask, acc_wval, acc_rdata;

    lpr_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .bypass     (bypass),
        .hw_gate_ok (hw_gate_ok),
        .acc_done   (acc_done),
        .acc_rdata  (acc_rdata),
        .last_try   (last_try),
        .resume     (resume),
        .busy       (busy),
        .done       (done),
        .err_code   (err_code),
        .acc_start  (acc_start),
        .acc_kind   (acc_kind),
        .acc_addr   (acc_addr),
        .acc_mask   (acc_mask),
        .acc_wval   (acc_wval),
        .restart    (restart),
        .miss       (miss)
    );

    lpr_poll_pacer #(
        .RETRY_MAX  (RETRY_MAX),
        .GAP_CYCLES (GAP_CYCLES)
    ) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .miss     (miss),
        .last_try (last_try),
        .resume   (resume)
    );

    lpr_bus_port u_port (
        .clk       (clk),
        .rst       (rst),
        .start     (acc_start),
        .kind      (acc_kind),
        .addr      (acc_addr),
        .mask      (acc_mask),
        .wval      (acc_wval),
        .acc_done  (acc_done),
        .acc_rdata (acc_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    // R11: the port stays quiet whenever no sequence runs
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);
    // R4: once a command ends (also on timeout) no access follows it
    a_r4_quiet_after_end: assert property (@(posedge clk) disable iff (rst)
        done |=> !bus_req);
endmodule

// File: tb/sim_lpr_sequencer.sv
module sim_lpr_sequencer;
    localparam int GAP   = 4;
    localparam int RETRY = 120;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        bypass = 1'b0;
    logic        hw_gate_ok = 1'b1;
    logic        busy, done, bus_req, bus_we, bus_ack;
    logic [2:0]  err_code;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    always #10 clk = ~clk;

    lpr_sequencer #(.RETRY_MAX(RETRY), .GAP_CYCLES(GAP)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .bypass(bypass), .hw_gate_ok(hw_gate_ok), .busy(busy), .done(done),
        .err_code(err_code), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    // ---------------- register-file slave model ----------------
    logic [31:0] regs [0:7];
    logic        dma_ok = 1'b1, stuck_up = 1'b0, stuck_dn = 1'b0, stuck_rst = 1'b0;
    logic        pre_en = 1'b0;
    logic [2:0]  pre_a = '0;
    logic [31:0] pre_d = '0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [3:0]  wlog_a [$];
    logic [31:0] wlog_d [$];

    function automatic logic [31:0] rd_val(logic [3:0] a);
        logic in_rst, ram_dn;
        in_rst = (regs[3][1:0] == 2'b01) || stuck_rst;
        ram_dn = stuck_dn ? 1'b1 : (stuck_up ? 1'b0 : (regs[4][1:0] == 2'b11));
        case (a)
            4'd2:    return {31'b0, regs[1][0] & dma_ok};
            4'd5:    return {30'b0, in_rst, ram_dn};
            default: return regs[a[2:0]];
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            for (int i = 0; i < 8; i++) regs[i] <= '0;
        end else begin
            bus_ack <= bus_req && !bus_ack;
            if (bus_req && !bus_ack) begin
                if (bus_we) begin
                    regs[bus_addr[2:0]] <= bus_wdata;
                    wr_cnt++;
                    wlog_a.push_back(bus_addr);
                    wlog_d.push_back(bus_wdata);
                end else begin
                    bus_rdata <= rd_val(bus_addr);
                    rd_cnt++;
                end
            end
            if (pre_en) regs[pre_a] <= pre_d;
        end
    end

    // ---------------- checking ----------------
    int tests = 0, fails = 0;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        int    err;
        int    rd;
        int    wr;
        int    rd0;
        int    wr0;
        string tag;
    } exp_t;
    exp_t exp_q [$];

    // monitor: pops one expectation per done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 done with no accepted command", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(err_code == 3'(e.err), {e.tag, " result code"}, err_code, e.err);
                check(!busy, {e.tag, " R9 busy low at done"}, busy, 0);
                if (e.rd >= 0)
                    check(rd_cnt - e.rd0 == e.rd, {e.tag, " read count"}, rd_cnt - e.rd0, e.rd);
                check(wr_cnt - e.wr0 == e.wr, {e.tag, " write count"}, wr_cnt - e.wr0, e.wr);
            end
        end
    end

    // driver
    task automatic issue(logic [1:0] op, int err, int rd, int wr, string tag, bit expect_it);
        exp_t e;
        @(negedge clk);
        e.err = err; e.rd = rd; e.wr = wr; e.rd0 = rd_cnt; e.wr0 = wr_cnt; e.tag = tag;
        if (expect_it) exp_q.push_back(e);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic preset(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_a = a; pre_d = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic chk_w(int idx, logic [3:0] a, logic [31:0] d, string tag);
        check(wlog_a[idx] == a && wlog_d[idx] == d, tag, {wlog_a[idx], wlog_d[idx]}, {a, d});
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int base, t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!busy && !done && !bus_req && err_code == 3'd0, "R11 reset state",
              {busy, done, bus_req, err_code}, 0);

        preset(3'd0, 32'h0000_0100);
        preset(3'd3, 32'hF0F0_F0F0);
        preset(3'd4, 32'hCCCC_CC00);

        // R1 enter order and values, R6 surrounding bits preserved
        base = wlog_a.size();
        issue(2'b01, 0, 6, 5, "R1 enter", 1);
        @(negedge clk);
        check(busy, "R9 busy while running", busy, 1);
        wait_idle();
        chk_w(base + 0, 4'd0, 32'h0000_0101, "R1 idle-force write");
        chk_w(base + 1, 4'd1, 32'h0000_0001, "R1 DMA pause write");
        chk_w(base + 2, 4'd3, 32'hF0F0_F0F1, "R1 reset override write");
        chk_w(base + 3, 4'd3, 32'hF0F0_F1F1, "R1 clock-gate override write");
        chk_w(base + 4, 4'd4, 32'hCCCC_CC03, "R6 RAM force write keeps other bits");

        // R2 quit with hardware gating allowed
        base = wlog_a.size();
        hw_gate_ok = 1'b1;
        issue(2'b10, 0, 6, 4, "R2 quit gating allowed", 1);
        wait_idle();
        chk_w(base + 0, 4'd4, 32'hCCCC_CC00, "R2 RAM force release");
        chk_w(base + 1, 4'd3, 32'hF0F0_F0F1, "R2 clock-gate release");
        chk_w(base + 2, 4'd3, 32'hF0F0_F0F2, "R2 reset override 10");
        chk_w(base + 3, 4'd4, 32'hCCCC_CC20, "R2 power-state 10");

        // R3 reset cycle from out of reset, gating not allowed
        base = wlog_a.size();
        hw_gate_ok = 1'b0;
        issue(2'b11, 0, 13, 9, "R3 cycle not in reset", 1);
        wait_idle();
        check(wlog_a[base] == 4'd0, "R3 enter ran first", wlog_a[base], 0);
        check(regs[4] == 32'hCCCC_CC30, "R2 power-state 11", regs[4], 32'hCCCC_CC30);
        check(regs[3] == 32'hF0F0_F0F2, "R6 core control after cycle", regs[3], 32'hF0F0_F0F2);

        // R3 reset cycle while already in reset: enter skipped
        hw_gate_ok = 1'b1;
        issue(2'b01, 0, 6, 5, "R1 enter again", 1);
        wait_idle();
        base = wlog_a.size();
        issue(2'b11, 0, 7, 4, "R3 cycle in reset", 1);
        wait_idle();
        check(wlog_a[base] == 4'd4, "R3 quit ran directly", wlog_a[base], 4);

        // R7 bypass
        bypass = 1'b1;
        issue(2'b01, 0, 0, 0, "R7 bypass", 1);
        check(done && !busy && err_code == 3'd0, "R7 done next cycle",
              {done, busy, err_code}, 5'b10000);
        wait_idle();
        bypass = 1'b0;

        // R8 command while busy is ignored
        base = wr_cnt;
        issue(2'b01, 0, 6, 5, "R8 first command", 1);
        repeat (6) @(negedge clk);
        issue(2'b10, 0, 0, 0, "R8 ignored", 0);
        wait_idle();
        repeat (40) @(negedge clk);
        check(wr_cnt - base == 5, "R8 no extra writes", wr_cnt - base, 5);
        check(exp_q.size() == 0 && !busy, "R8 idle after", busy, 0);

        // leave reset before timeout tests
        issue(2'b10, 0, 6, 4, "R2 quit", 1);
        wait_idle();

        // R4/R5 DMA pause timeout, with read budget and pacing
        dma_ok = 1'b0;
        preset(3'd1, 32'h0);
        base = wlog_a.size();
        t0 = cyc;
        issue(2'b01, 1, 1 + RETRY, 2, "R5 DMA timeout code 1", 1);
        wait_idle();
        check(cyc - t0 >= (RETRY - 1) * GAP, "R4 poll pacing", cyc - t0, (RETRY - 1) * GAP);
        check(regs[3] == 32'hF0F0_F0F2, "R4 no write after timeout", regs[3], 32'hF0F0_F0F2);
        dma_ok = 1'b1;

        // R5 RAM-down timeout
        stuck_up = 1'b1;
        issue(2'b01, 2, 5 + RETRY, 5, "R5 RAM-down timeout code 2", 1);
        wait_idle();
        stuck_up = 1'b0;

        // R5 RAM-up timeout
        stuck_dn = 1'b1;
        issue(2'b10, 3, 3 + RETRY, 3, "R5 RAM-up timeout code 3", 1);
        wait_idle();
        stuck_dn = 1'b0;

        // R5 reset-release timeout
        stuck_rst = 1'b1;
        issue(2'b10, 4, 4 + RETRY, 3, "R5 reset-release timeout code 4", 1);
        wait_idle();
        stuck_rst = 1'b0;

        // R4 poll succeeds after several misses within budget
        dma_ok = 1'b0;
        preset(3'd1, 32'h0);
        issue(2'b01, 0, -1, 5, "R4 late DMA pause", 1);
        repeat (30) @(negedge clk);
        dma_ok = 1'b1;
        wait_idle();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule